// File: doc/BRIEF.md
# Eight-Channel Block and Scanline Transfer Scheduler

This block decides which of eight shared transfer channels may use the shared buses, one channel at a time. A channel can run a block copy, which starts on a one-cycle start bit and runs until the channel reports its last unit. It can also run as a scanline table channel. Table channels are armed at the start of each frame. After that, they are serviced once per display line inside a fixed horizontal window. The channel datapaths sit outside this block. They see a one-hot grant and a phase code, and they answer each grant with a done pulse. The done pulse carries the byte count, a pointer-reload flag and an end flag.

Scanline work always comes before block work. When table channels become due, every block copy in progress is paused. A block copy on a channel that has just become due for table work is cancelled at once, and a one-cycle kill pulse goes to that channel. Once the table channels have been served, the paused block copies continue from where they stopped, lowest channel first. The CPU stall output is high for the whole of any activity. A running master-cycle cost counter adds the fixed overheads and the per-byte charges of the current stall episode. It holds its last total until the next episode starts.

Top module: `xfer_sched`

## Requirements
- R1: After reset, grant, kill, last_active and cpu_stall are 0, grant_mode is 0 and cost is 0.
- R2: At most one grant bit is set. Among the channels that are eligible in the current phase, the lowest-numbered one holds the grant. Block copies therefore complete in ascending channel order.
- R3: cpu_stall is high in every cycle in which grant_mode is not 0, and grant_mode is 0 when nothing is pending. The phase codes are 0 idle, 1 block copy, 2 frame init and 3 line service.
- R4: When vpos is 0 and hpos reaches INIT_H, every channel set in hdma_en is granted once in phase 2, in ascending order. This episode costs LINE_OVH + 8 per direct channel + 24 per indirect channel (18 + 8d + 24i by default).
- R5: When hpos reaches LINE_H on a line with vpos at most LAST_LINE, every table channel that is still armed is granted once in phase 3, in ascending order. No service occurs on lines with vpos above LAST_LINE.
- R6: A line service costs 18, plus 8 per served channel, plus 16 per done with chan_reload set, plus 8 per byte reported. With eight channels that each reload and move 4 bytes, the cost is 466.
- R7: A line service preempts a running block copy. kill pulses for one cycle on every busy block channel that is also armed for table work, and that channel's copy ends. The other paused copies resume in phase 1 once the service finishes and move all of their bytes.
- R8: A done with chan_end set during phase 2 or phase 3 disarms that channel for the rest of the frame, so later lines skip it.
- R9: last_active is high during a phase 3 grant exactly when no higher-numbered channel is still waiting on the current line.
- R10: A block-copy episode that starts from idle costs DMA_OVH (16), plus 8 each time a channel takes the grant, plus 8 per byte reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_start | input | NCH | One-cycle start bits for block copies |
| hdma_en | input | NCH | Table channels armed at frame init |
| hdma_indirect | input | NCH | Table channel uses an indirect pointer |
| hpos | input | HW | Horizontal dot position |
| vpos | input | VW | Vertical line number |
| chan_done | input | 1 | Served channel finished its unit this cycle |
| chan_bytes | input | 3 | Bytes moved by that unit |
| chan_reload | input | 1 | Unit reloaded an indirect pointer |
| chan_end | input | 1 | Channel has finished (count exhausted or table end) |
| grant | output | NCH | One-hot bus grant |
| grant_mode | output | 2 | Phase code: 0 idle, 1 block, 2 init, 3 line |
| kill | output | NCH | One-cycle cancel of a conflicting block copy |
| last_active | output | 1 | No higher channel is waiting on this line |
| cpu_stall | output | 1 | CPU held while any transfer activity runs |
| cost | output | COST_W | Master-cycle cost of the current or last episode |

## Verification
The assertions assume that chan_done appears only while a grant is held. They also assume that init and line positions are never reached while a line service is still running, and that each start bit names a channel with no copy already running. The bench's channel model answers only a live grant. It leaves several idle cycles between scanline positions and waits for cpu_stall to fall before the next scenario. It raises start bits only for channels whose copies have finished.

// File: rtl/xfer_sched_pkg.sv
// Package: phase encoding shared by the scheduler and its checker.
// Assumes: the phase code doubles as the grant_mode output.
package xfer_sched_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLOCK = 2'd1,
        PH_INIT  = 2'd2,
        PH_LINE  = 2'd3
    } phase_t;
endpackage

// File: rtl/xfer_sched_timing.sv
// Module: turns raster positions into single-cycle init and line strobes.
// Assumes: hpos and vpos are synchronous to clk and each position is held
// for at least one cycle; a strobe fires on the first cycle of a match.
module xfer_sched_timing #(
    parameter int HW        = 9,
    parameter int VW        = 9,
    parameter int INIT_H    = 6,
    parameter int LINE_H    = 278,
    parameter int LAST_LINE = 224
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vpos,
    output logic          init_hit,
    output logic          line_hit
);
    logic init_match, line_match, init_q, line_q;

    // Purpose: decode the two raster positions of interest.
    always_comb begin
        init_match = (vpos == VW'(0)) && (hpos == HW'(INIT_H));
        line_match = (hpos == HW'(LINE_H)) && (vpos <= VW'(LAST_LINE));
    end

    // Purpose: remember last cycle's matches for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            line_q <= 1'b0;
        end else begin
            init_q <= init_match;
            line_q <= line_match;
        end
    end

    assign init_hit = init_match & ~init_q;
    assign line_hit = line_match & ~line_q;
endmodule

// File: rtl/xfer_sched_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes: nothing about req; also reports whether the winner is the
// highest requester (no request above it).
module xfer_sched_pick #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] gnt,
    output logic           top_winner
);
    logic [NCH:0]   low_or;
    logic [NCH:0]   high_or;
    logic [NCH-1:0] is_top;

    assign low_or[0]    = 1'b0;
    assign high_or[NCH] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        assign low_or[i+1] = low_or[i] | req[i];
        assign high_or[i]  = high_or[i+1] | req[i];
        assign gnt[i]      = req[i] & ~low_or[i];
        assign is_top[i]   = gnt[i] & ~high_or[i+1];
    end

    assign top_winner = |is_top;
endmodule

// File: rtl/xfer_sched_cost.sv
// Module: master-cycle cost accumulator for one stall episode.
// Assumes: 'fresh' marks the cycle an episode leaves idle; 'entry' is the
// one-time overhead chosen by the sequencer for that cycle.
module xfer_sched_cost
    import xfer_sched_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int COST_W    = 16,
    parameter int CH_OVH    = 8,
    parameter int PTR_COST  = 16,
    parameter int BYTE_COST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic [NCH-1:0]    gnt,
    input  logic              gnt_indirect,
    input  logic              served,
    input  logic [2:0]        bytes,
    input  logic              reload,
    input  logic              fresh,
    input  logic [COST_W-1:0] entry,
    output logic [COST_W-1:0] cost
);
    logic [NCH+1:0]    prev_key;
    logic [NCH+1:0]    cur_key;
    logic [COST_W-1:0] grant_chg, done_chg, byte_chg;

    assign cur_key  = {phase, gnt};
    assign byte_chg = COST_W'(BYTE_COST) * COST_W'(bytes);

    // Purpose: charge each new (phase, channel) grant and each finished unit.
    always_comb begin
        grant_chg = '0;
        done_chg  = '0;
        if ((|gnt) && (cur_key != prev_key)) begin
            grant_chg = COST_W'(CH_OVH);
            if (phase == PH_INIT && gnt_indirect)
                grant_chg = COST_W'(CH_OVH + PTR_COST);
        end
        if (served) begin
            if (phase == PH_BLOCK)
                done_chg = byte_chg;
            else if (phase == PH_LINE)
                done_chg = byte_chg + (reload ? COST_W'(PTR_COST) : '0);
        end
    end

    // Purpose: hold the previous grant key and accumulate the episode cost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_key <= '0;
            cost     <= '0;
        end else begin
            prev_key <= cur_key;
            cost     <= (fresh ? '0 : cost) + entry + grant_chg + done_chg;
        end
    end
endmodule

// File: rtl/xfer_sched.sv
// Module: top of the eight-channel transfer scheduler.
// Sequences idle, block copy, frame init and line service phases, grants
// one channel at a time by fixed priority, cancels conflicting block copies
// and stalls the CPU throughout.
// Assumes: chan_done only while a grant is held; init/line positions are
// not reached while a line service is still running.
module xfer_sched
    import xfer_sched_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int HW        = 9,
    parameter int VW        = 9,
    parameter int COST_W    = 16,
    parameter int INIT_H    = 6,
    parameter int LINE_H    = 278,
    parameter int LAST_LINE = 224,
    parameter int LINE_OVH  = 18,
    parameter int CH_OVH    = 8,
    parameter int PTR_COST  = 16,
    parameter int BYTE_COST = 8,
    parameter int DMA_OVH   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    dma_start,
    input  logic [NCH-1:0]    hdma_en,
    input  logic [NCH-1:0]    hdma_indirect,
    input  logic [HW-1:0]     hpos,
    input  logic [VW-1:0]     vpos,
    input  logic              chan_done,
    input  logic [2:0]        chan_bytes,
    input  logic              chan_reload,
    input  logic              chan_end,
    output logic [NCH-1:0]    grant,
    output logic [1:0]        grant_mode,
    output logic [NCH-1:0]    kill,
    output logic              last_active,
    output logic              cpu_stall,
    output logic [COST_W-1:0] cost
);
    phase_t            state, state_n;
    logic [NCH-1:0]    dma_busy, busy_n;
    logic [NCH-1:0]    due, due_n;
    logic [NCH-1:0]    armed, armed_n;
    logic [NCH-1:0]    kill_n, req, gnt;
    logic              init_hit, line_hit, top_winner, served, fresh;
    logic [COST_W-1:0] entry;

    xfer_sched_timing #(
        .HW(HW), .VW(VW), .INIT_H(INIT_H), .LINE_H(LINE_H), .LAST_LINE(LAST_LINE)
    ) i_timing (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
        .init_hit(init_hit), .line_hit(line_hit)
    );

    // Purpose: select the request set eligible in the current phase.
    always_comb begin
        unique case (state)
            PH_BLOCK:        req = dma_busy;
            PH_INIT, PH_LINE: req = due;
            default:         req = '0;
        endcase
    end

    xfer_sched_pick #(.NCH(NCH)) i_pick (
        .req(req), .gnt(gnt), .top_winner(top_winner)
    );

    assign served = chan_done & (|gnt);

    // Purpose: next-state logic for phase, pending masks and kill pulses.
    always_comb begin
        state_n = state;
        busy_n  = dma_busy | dma_start;
        due_n   = due;
        armed_n = armed;
        kill_n  = '0;
        fresh   = 1'b0;
        entry   = '0;
        if (served) begin
            if (state == PH_BLOCK) begin
                if (chan_end) busy_n = busy_n & ~gnt;
            end else begin
                due_n = due_n & ~gnt;
                if (chan_end) armed_n = armed_n & ~gnt;
            end
        end
        if (state == PH_IDLE || state == PH_BLOCK) begin
            if (init_hit) begin
                armed_n = hdma_en;
                due_n   = hdma_en;
                kill_n  = busy_n & hdma_en;
                busy_n  = busy_n & ~hdma_en;
            end else if (line_hit && (|armed_n)) begin
                due_n   = armed_n;
                kill_n  = busy_n & armed_n;
                busy_n  = busy_n & ~armed_n;
            end
            if ((init_hit || line_hit) && (|due_n)) begin
                state_n = (init_hit) ? PH_INIT : PH_LINE;
                entry   = COST_W'(LINE_OVH);
                fresh   = (state == PH_IDLE);
            end else begin
                state_n = (|busy_n) ? PH_BLOCK : PH_IDLE;
                if (state == PH_IDLE && (|busy_n)) begin
                    entry = COST_W'(DMA_OVH);
                    fresh = 1'b1;
                end
            end
        end else if (due_n == '0) begin
            state_n = (|busy_n) ? PH_BLOCK : PH_IDLE;
        end
    end

    // Purpose: register phase, masks and the kill pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            dma_busy <= '0;
            due      <= '0;
            armed    <= '0;
            kill     <= '0;
        end else begin
            state    <= state_n;
            dma_busy <= busy_n;
            due      <= due_n;
            armed    <= armed_n;
            kill     <= kill_n;
        end
    end

    xfer_sched_cost #(
        .NCH(NCH), .COST_W(COST_W), .CH_OVH(CH_OVH),
        .PTR_COST(PTR_COST), .BYTE_COST(BYTE_COST)
    ) i_cost (
        .clk(clk), .rst_n(rst_n), .phase(state), .gnt(gnt),
        .gnt_indirect(|(gnt & hdma_indirect)), .served(served),
        .bytes(chan_bytes), .reload(chan_reload), .fresh(fresh),
        .entry(entry), .cost(cost)
    );

    assign grant       = gnt;
    assign grant_mode  = state;
    assign cpu_stall   = (state != PH_IDLE);
    assign last_active = (state == PH_LINE) & top_winner;
endmodule

// File: rtl/xfer_sched_chk.sv
// Module: property checker for the scheduler, bound to every instance.
// Assumes: observes ports only; reset is synchronous and active-low.
module xfer_sched_chk #(
    parameter int NCH    = 8,
    parameter int COST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    grant,
    input logic [1:0]        grant_mode,
    input logic [NCH-1:0]    kill,
    input logic              last_active,
    input logic              cpu_stall,
    input logic [COST_W-1:0] cost
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_STALL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> cpu_stall); // R3

    AST_MODE_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (grant_mode != 2'd0)); // R3

    AST_LAST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        last_active |-> (grant != '0 && grant_mode == 2'd3)); // R9

    AST_KILL_OUTSIDE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (kill != '0) |-> (grant_mode == 2'd2 || grant_mode == 2'd3)); // R7

    AST_COST_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && $past(cpu_stall)) |-> (cost >= $past(cost))); // R6
endmodule

bind xfer_sched xfer_sched_chk #(.NCH(NCH), .COST_W(COST_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_mode(grant_mode),
    .kill(kill), .last_active(last_active), .cpu_stall(cpu_stall), .cost(cost)
);

// File: tb/test_xfer_sched.sv
// Bench: directed scenarios with a behavioural channel model answering grants.
module test_xfer_sched;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dma_start = '0, hdma_en = '0, hdma_indirect = '0;
    logic [8:0]  hpos = 9'h050, vpos = 9'h0F0;
    logic        chan_done = 1'b0, chan_reload = 1'b0, chan_end = 1'b0;
    logic [2:0]  chan_bytes = '0;
    logic [7:0]  grant, kill;
    logic [1:0]  grant_mode;
    logic        last_active, cpu_stall;
    logic [15:0] cost;

    int errors = 0, checks = 0;

    // channel model state
    int dma_left [NCH];
    int dma_moved[NCH];
    int lbytes   [NCH];
    bit lrel     [NCH];
    bit lend     [NCH];
    bit iend     [NCH];

    // grant log
    int log_ch[64], log_md[64];
    bit log_last[64];
    int log_n = 0;
    logic [9:0] prev_key = '0;
    logic [7:0] kill_seen = '0;

    always #10 clk = ~clk;

    xfer_sched i_xfer_sched (
        .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .hdma_en(hdma_en),
        .hdma_indirect(hdma_indirect), .hpos(hpos), .vpos(vpos),
        .chan_done(chan_done), .chan_bytes(chan_bytes), .chan_reload(chan_reload),
        .chan_end(chan_end), .grant(grant), .grant_mode(grant_mode), .kill(kill),
        .last_active(last_active), .cpu_stall(cpu_stall), .cost(cost)
    );

    function automatic int idx_of(logic [7:0] g);
        for (int i = 0; i < NCH; i++) if (g[i]) return i;
        return -1;
    endfunction

    // Monitor and channel model, both away from the active edge.
    always @(negedge clk) begin
        int ch;
        kill_seen = kill_seen | kill;
        ch = idx_of(grant);
        if (grant != '0 && {grant_mode, grant} != prev_key && log_n < 64) begin
            log_ch[log_n] = ch; log_md[log_n] = grant_mode;
            log_last[log_n] = last_active; log_n++;
        end
        prev_key = {grant_mode, grant};
        chan_done = 1'b0; chan_bytes = '0; chan_reload = 1'b0; chan_end = 1'b0;
        if (ch >= 0) begin
            chan_done = 1'b1;
            case (grant_mode)
                2'd1: begin
                    chan_bytes = 3'd1;
                    chan_end = (dma_left[ch] == 1);
                    dma_left[ch]--; dma_moved[ch]++;
                end
                2'd2: chan_end = iend[ch];
                2'd3: begin
                    chan_bytes = 3'(lbytes[ch]);
                    chan_reload = lrel[ch];
                    chan_end = lend[ch];
                end
                default: chan_done = 1'b0;
            endcase
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0; kill_seen = '0;
        for (int i = 0; i < NCH; i++) begin
            lbytes[i] = 0; lrel[i] = 0; lend[i] = 0; iend[i] = 0; dma_moved[i] = 0;
        end
    endtask

    task automatic run_until_idle(string req);
        bit seen = cpu_stall;
        int n = 0;
        while (n < 400) begin
            @(negedge clk);
            if (cpu_stall) seen = 1;
            else if (seen) break;
            n++;
        end
        check(n < 400, req, "episode finished", n, 0);
    endtask

    task automatic raster(int v, int h);
        @(negedge clk); vpos = 9'(v); hpos = 9'(h);
        @(negedge clk); hpos = 9'h050;
    endtask

    task automatic t_reset();
        check(grant == 0 && kill == 0 && !last_active, "R1", "grant/kill/last", grant, 0);
        check(!cpu_stall && grant_mode == 0, "R1", "stall/mode", grant_mode, 0);
        check(cost == 0, "R1", "cost", cost, 0);
    endtask

    task automatic t_block_order();
        clear_log();
        dma_left[2] = 3; dma_left[5] = 2;
        @(negedge clk); dma_start = 8'h24;
        @(negedge clk); dma_start = '0;
        check(cpu_stall && grant_mode == 1, "R3", "stall in block", grant_mode, 1);
        run_until_idle("R2");
        check(log_n == 2 && log_ch[0] == 2 && log_ch[1] == 5, "R2", "first served", log_ch[0], 2);
        check(dma_moved[2] == 3 && dma_moved[5] == 2, "R2", "bytes ch5", dma_moved[5], 2);
        check(cost == 72, "R10", "block cost", cost, 72);
        check(grant_mode == 0 && !cpu_stall, "R3", "idle after", grant_mode, 0);
    endtask

    task automatic t_init();
        clear_log();
        hdma_en = 8'h85; hdma_indirect = 8'h04;
        raster(0, 6);
        run_until_idle("R4");
        check(log_n == 3 && log_ch[0] == 0 && log_ch[1] == 2 && log_ch[2] == 7,
              "R4", "init order last", log_ch[2], 7);
        check(log_md[0] == 2, "R4", "init phase", log_md[0], 2);
        check(cost == 58, "R4", "init cost", cost, 58);
    endtask

    task automatic t_line();
        clear_log();
        lbytes[0] = 1; lbytes[2] = 2; lrel[2] = 1; lbytes[7] = 4;
        raster(5, 278);
        run_until_idle("R5");
        check(log_n == 3 && log_ch[1] == 2 && log_md[2] == 3, "R5", "line order", log_n, 3);
        check(cost == 114, "R6", "line cost", cost, 114);
        check(log_last[2] == 1 && log_last[0] == 0, "R9", "last flag ch7", log_last[2], 1);
    endtask

    task automatic t_no_line_past_end();
        bit any = 0;
        clear_log();
        @(negedge clk); vpos = 9'h0E5; hpos = 9'd278;
        repeat (5) begin @(negedge clk); any |= cpu_stall; end
        hpos = 9'h050;
        check(!any && log_n == 0, "R5", "stall beyond last line", any, 0);
    endtask

    task automatic t_worst();
        clear_log();
        hdma_en = 8'hFF; hdma_indirect = 8'hFF;
        raster(0, 6);
        run_until_idle("R4");
        check(cost == 210, "R4", "init cost all indirect", cost, 210);
        clear_log();
        for (int i = 0; i < NCH; i++) begin lbytes[i] = 4; lrel[i] = 1; end
        raster(10, 278);
        run_until_idle("R6");
        check(cost == 466, "R6", "worst line cost", cost, 466);
        check(log_n == 8 && log_ch[7] == 7, "R5", "all served", log_n, 8);
    endtask

    task automatic t_preempt();
        clear_log();
        hdma_en = 8'h08; hdma_indirect = '0;
        raster(0, 6);
        run_until_idle("R4");
        clear_log();
        dma_left[3] = 10; dma_left[6] = 20; lbytes[3] = 1;
        @(negedge clk); dma_start = 8'h48;
        @(negedge clk); dma_start = '0;
        @(negedge clk);
        raster(7, 278);
        run_until_idle("R7");
        check(kill_seen == 8'h08, "R7", "kill mask", kill_seen, 8);
        check(log_n == 3 && log_ch[0] == 3 && log_md[0] == 1 && log_ch[1] == 3 &&
              log_md[1] == 3 && log_ch[2] == 6 && log_md[2] == 1,
              "R7", "preempt sequence length", log_n, 3);
        check(dma_moved[6] == 20, "R7", "resumed bytes ch6", dma_moved[6], 20);
        check(dma_moved[3] > 0 && dma_moved[3] < 10, "R7", "killed bytes ch3", dma_moved[3], 3);
    endtask

    task automatic t_disarm();
        clear_log();
        hdma_en = 8'h03; hdma_indirect = '0;
        raster(0, 6);
        run_until_idle("R4");
        clear_log();
        lend[0] = 1;
        raster(1, 278);
        run_until_idle("R8");
        check(log_n == 2 && log_last[0] == 0 && log_last[1] == 1, "R9", "last on ch1", log_n, 2);
        clear_log();
        raster(2, 278);
        run_until_idle("R8");
        check(log_n == 1 && log_ch[0] == 1, "R8", "disarmed ch0 skipped", log_ch[0], 1);
        check(log_last[0] == 1, "R9", "single channel is last", log_last[0], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) dma_left[i] = 0;
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_block_order();
        t_init();
        t_line();
        t_no_line_past_end();
        t_worst();
        t_preempt();
        t_disarm();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule